// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two parallel buses, an A side and a B side, through a pair of capture registers. One register stores data moving from A towards B, and the other stores data moving from B towards A. Each outgoing path chooses between the live value on the opposite bus and the contents of its register. A direction bit and an active-low output enable decide which side, if either, is driven. Bidirectional pads are split into separate input, output and drive-enable signals for each port.

The width is organised as lanes, which are 8 bits wide by default, with two lanes by default. Each lane has its own set of controls, so the default build behaves as two independent byte transceivers. Setting the `TIE_LANES` parameter makes lane 0's controls govern every lane, and the block then acts as one full-width transceiver.

Capture is synchronous: a capture strobe that is high at a rising edge of `clk` loads the register. The output multiplexers are combinational. Each one is built as a two-input AND-OR with a consensus term, so flipping a select while both sources agree cannot disturb the output.

Top module: `regbus_xcvr`

## Requirements
- R1: A synchronous active-high `rst` clears both registers of every lane to zero. It has priority over capture. After reset, a lane with its select at 1 shows 0 on that path.
- R2: When `cap_ab[l]` is 1 at a rising clock edge, that lane's A-to-B register loads the lane's `a_in` bits. Otherwise the register keeps its value.
- R3: When `cap_ba[l]` is 1 at a rising clock edge, that lane's B-to-A register loads the lane's `b_in` bits. Otherwise the register keeps its value.
- R4: With `sel_ab[l]`=0, the lane's `b_out` bits equal its live `a_in` bits in the same cycle. With `sel_ab[l]`=1, they equal the A-to-B register.
- R5: With `sel_ba[l]`=0, the lane's `a_out` bits equal its live `b_in` bits in the same cycle. With `sel_ba[l]`=1, they equal the B-to-A register.
- R6: With `oe_n[l]`=0, `dir[l]`=1 sets `b_drive[l]` and `dir[l]`=0 sets `a_drive[l]`. With `oe_n[l]`=1, neither drive is set.
- R7: `a_drive[l]` and `b_drive[l]` are never 1 together.
- R8: Capture works whatever the values of `oe_n` and `dir`. With outputs disabled, both registers of a lane can load in the same cycle.
- R9: With `TIE_LANES`=0, the controls of lane l affect only bits [l*8 +: 8] and drive bit l.
- R10: With `TIE_LANES`=1, lane 0's control bits govern every lane, and the control bits of the other lanes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock |
| rst | input | 1 | Synchronous active-high reset of the registers |
| a_in | input | LANES*LANE_W | Value seen on the A pads |
| b_in | input | LANES*LANE_W | Value seen on the B pads |
| oe_n | input | LANES | Active-low output enable per lane |
| dir | input | LANES | 1: drive B, 0: drive A |
| sel_ab | input | LANES | B output source: 0 live A, 1 stored |
| sel_ba | input | LANES | A output source: 0 live B, 1 stored |
| cap_ab | input | LANES | Load the A-to-B register at the clock edge |
| cap_ba | input | LANES | Load the B-to-A register at the clock edge |
| a_out | output | LANES*LANE_W | Value for the A pads |
| b_out | output | LANES*LANE_W | Value for the B pads |
| a_drive | output | LANES | Enable the A pad drivers of a lane |
| b_drive | output | LANES | Enable the B pad drivers of a lane |

## Verification
The hardest state to reach is isolation capture: outputs disabled, both registers of a lane loading in the same edge, and the stored values then read out through both selects. The bench reaches it with a directed phase. That phase raises `oe_n`, strobes both captures with distinct patterns, then flips the selects and compares the stored data. Lane independence needs stimulus in which one lane's controls stay frozen while the other sweeps all sixteen enable, direction and select combinations. A second, tied instance receives conflicting upper-lane controls to show that they are ignored.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef struct packed {
    logic oe_n;
    logic dir;
    logic sel_ab;
    logic sel_ba;
    logic cap_ab;
    logic cap_ba;
  } lane_ctrl_t;
endpackage

// File: rtl/xcvr_store_reg.sv
module xcvr_store_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (cap) q <= d;
  end
endmodule

// File: rtl/xcvr_hazfree_mux.sv
module xcvr_hazfree_mux #(
  parameter int W = 8
) (
  input  logic         sel,
  input  logic [W-1:0] live,
  input  logic [W-1:0] stored,
  output logic [W-1:0] y
);
  // consensus term keeps y steady when live and stored agree across a select flip
  always_comb begin
    y = ({W{~sel}} & live) | ({W{sel}} & stored) | (live & stored);
  end
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  lane_ctrl_t   ctrl,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] b_out,
  output logic         a_drive,
  output logic         b_drive
);
  logic [W-1:0] q_ab, q_ba;

  xcvr_store_reg #(.W(W)) u_reg_ab (
    .clk(clk), .rst(rst), .cap(ctrl.cap_ab), .d(a_in), .q(q_ab));
  xcvr_store_reg #(.W(W)) u_reg_ba (
    .clk(clk), .rst(rst), .cap(ctrl.cap_ba), .d(b_in), .q(q_ba));

  xcvr_hazfree_mux #(.W(W)) u_mux_b (
    .sel(ctrl.sel_ab), .live(a_in), .stored(q_ab), .y(b_out));
  xcvr_hazfree_mux #(.W(W)) u_mux_a (
    .sel(ctrl.sel_ba), .live(b_in), .stored(q_ba), .y(a_out));

  always_comb begin
    b_drive = ~ctrl.oe_n & ctrl.dir;
    a_drive = ~ctrl.oe_n & ~ctrl.dir;
  end
endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr
  import xcvr_pkg::*;
#(
  parameter int LANE_W    = 8,
  parameter int LANES     = 2,
  parameter bit TIE_LANES = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [LANES*LANE_W-1:0] a_in,
  input  logic [LANES*LANE_W-1:0] b_in,
  input  logic [LANES-1:0]        oe_n,
  input  logic [LANES-1:0]        dir,
  input  logic [LANES-1:0]        sel_ab,
  input  logic [LANES-1:0]        sel_ba,
  input  logic [LANES-1:0]        cap_ab,
  input  logic [LANES-1:0]        cap_ba,
  output logic [LANES*LANE_W-1:0] a_out,
  output logic [LANES*LANE_W-1:0] b_out,
  output logic [LANES-1:0]        a_drive,
  output logic [LANES-1:0]        b_drive
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam int CI = TIE_LANES ? 0 : l;
    lane_ctrl_t ctrl;
    always_comb begin
      ctrl.oe_n   = oe_n[CI];
      ctrl.dir    = dir[CI];
      ctrl.sel_ab = sel_ab[CI];
      ctrl.sel_ba = sel_ba[CI];
      ctrl.cap_ab = cap_ab[CI];
      ctrl.cap_ba = cap_ba[CI];
    end
    xcvr_lane #(.W(LANE_W)) u_lane (
      .clk    (clk),
      .rst    (rst),
      .ctrl   (ctrl),
      .a_in   (a_in[l*LANE_W +: LANE_W]),
      .b_in   (b_in[l*LANE_W +: LANE_W]),
      .a_out  (a_out[l*LANE_W +: LANE_W]),
      .b_out  (b_out[l*LANE_W +: LANE_W]),
      .a_drive(a_drive[l]),
      .b_drive(b_drive[l])
    );
  end
endmodule

// File: rtl/xcvr_chk.sv
module xcvr_chk #(
  parameter int LANE_W    = 8,
  parameter int LANES     = 2,
  parameter bit TIE_LANES = 1'b0
) (
  input logic                    clk,
  input logic                    rst,
  input logic [LANES*LANE_W-1:0] a_in,
  input logic [LANES*LANE_W-1:0] b_in,
  input logic [LANES-1:0]        oe_n,
  input logic [LANES-1:0]        sel_ab,
  input logic [LANES-1:0]        sel_ba,
  input logic [LANES-1:0]        cap_ab,
  input logic [LANES-1:0]        cap_ba,
  input logic [LANES*LANE_W-1:0] a_out,
  input logic [LANES*LANE_W-1:0] b_out,
  input logic [LANES-1:0]        a_drive,
  input logic [LANES-1:0]        b_drive
);
  for (genvar l = 0; l < LANES; l++) begin : g_chk
    localparam int C = TIE_LANES ? 0 : l;

    // R7
    one_side_chk: assert property (@(posedge clk) disable iff (rst)
      !(a_drive[l] && b_drive[l]));

    // R6
    idle_outputs_chk: assert property (@(posedge clk) disable iff (rst)
      oe_n[C] |-> (!a_drive[l] && !b_drive[l]));

    // R4
    live_b_chk: assert property (@(posedge clk) disable iff (rst)
      !sel_ab[C] |-> (b_out[l*LANE_W +: LANE_W] == a_in[l*LANE_W +: LANE_W]));

    // R5
    live_a_chk: assert property (@(posedge clk) disable iff (rst)
      !sel_ba[C] |-> (a_out[l*LANE_W +: LANE_W] == b_in[l*LANE_W +: LANE_W]));

    // R2
    store_ab_chk: assert property (@(posedge clk) disable iff (rst)
      cap_ab[C] |=> (!sel_ab[C] ||
        b_out[l*LANE_W +: LANE_W] == $past(a_in[l*LANE_W +: LANE_W])));

    // R3
    store_ba_chk: assert property (@(posedge clk) disable iff (rst)
      cap_ba[C] |=> (!sel_ba[C] ||
        a_out[l*LANE_W +: LANE_W] == $past(b_in[l*LANE_W +: LANE_W])));

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(rst) && sel_ab[C]) |-> (b_out[l*LANE_W +: LANE_W] == '0));
  end
endmodule

bind regbus_xcvr xcvr_chk #(
  .LANE_W(LANE_W), .LANES(LANES), .TIE_LANES(TIE_LANES)
) u_chk (
  .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .oe_n(oe_n),
  .sel_ab(sel_ab), .sel_ba(sel_ba), .cap_ab(cap_ab), .cap_ba(cap_ba),
  .a_out(a_out), .b_out(b_out), .a_drive(a_drive), .b_drive(b_drive)
);

// File: tb/tb_regbus_xcvr.sv
module tb_regbus_xcvr;
  localparam int LW = 8;
  localparam int NL = 2;
  localparam int TW = LW * NL;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [TW-1:0] a_in = '0, b_in = '0;
  logic [NL-1:0] oe_n = '1, dir = '0, sel_ab = '0, sel_ba = '0, cap_ab = '0, cap_ba = '0;
  logic [TW-1:0] a_out, b_out, t_a_out, t_b_out;
  logic [NL-1:0] a_drive, b_drive, t_a_drive, t_b_drive;

  always #2.5 clk = ~clk;

  regbus_xcvr #(.LANE_W(LW), .LANES(NL), .TIE_LANES(1'b0)) dut (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .oe_n(oe_n), .dir(dir),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .cap_ab(cap_ab), .cap_ba(cap_ba),
    .a_out(a_out), .b_out(b_out), .a_drive(a_drive), .b_drive(b_drive));

  regbus_xcvr #(.LANE_W(LW), .LANES(NL), .TIE_LANES(1'b1)) dut_tied (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .oe_n(oe_n), .dir(dir),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .cap_ab(cap_ab), .cap_ba(cap_ba),
    .a_out(t_a_out), .b_out(t_b_out), .a_drive(t_a_drive), .b_drive(t_b_drive));

  int checks = 0;
  int fails  = 0;
  int m_ab[NL], m_ba[NL], t_ab[NL], t_ba[NL];

  task automatic cmp(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s got %h exp %h", req, what, got, exp);
    end
  endtask

  // compares both instances with the behavioural model, then advances one edge
  task automatic step(input string req, input bit do_chk);
    #1;
    if (do_chk) begin
      for (int l = 0; l < NL; l++) begin
        int ai = a_in[l*LW +: LW];
        int bi = b_in[l*LW +: LW];
        cmp(req, $sformatf("lane%0d b_out", l), b_out[l*LW +: LW], sel_ab[l] ? m_ab[l] : ai);
        cmp(req, $sformatf("lane%0d a_out", l), a_out[l*LW +: LW], sel_ba[l] ? m_ba[l] : bi);
        cmp(req, $sformatf("lane%0d b_drive", l), b_drive[l], !oe_n[l] && dir[l]);
        cmp(req, $sformatf("lane%0d a_drive", l), a_drive[l], !oe_n[l] && !dir[l]);
        cmp({req, " R10"}, $sformatf("tied lane%0d b_out", l), t_b_out[l*LW +: LW], sel_ab[0] ? t_ab[l] : ai);
        cmp({req, " R10"}, $sformatf("tied lane%0d a_out", l), t_a_out[l*LW +: LW], sel_ba[0] ? t_ba[l] : bi);
        cmp({req, " R10"}, $sformatf("tied lane%0d drives", l), {t_a_drive[l], t_b_drive[l]},
            {!oe_n[0] && !dir[0], !oe_n[0] && dir[0]});
        cmp("R7", $sformatf("lane%0d both drives", l), a_drive[l] & b_drive[l], 0);
      end
    end
    @(posedge clk);
    for (int l = 0; l < NL; l++) begin
      if (rst) begin
        m_ab[l] = 0; m_ba[l] = 0; t_ab[l] = 0; t_ba[l] = 0;
      end else begin
        if (cap_ab[l]) m_ab[l] = a_in[l*LW +: LW];
        if (cap_ba[l]) m_ba[l] = b_in[l*LW +: LW];
        if (cap_ab[0]) t_ab[l] = a_in[l*LW +: LW];
        if (cap_ba[0]) t_ba[l] = b_in[l*LW +: LW];
      end
    end
    @(negedge clk);
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int l = 0; l < NL; l++) begin m_ab[l] = 0; m_ba[l] = 0; t_ab[l] = 0; t_ba[l] = 0; end
    @(negedge clk);
    a_in = 16'hA5C3; b_in = 16'h3C5A; cap_ab = '1; cap_ba = '1;
    step("R1", 1'b0);
    step("R1", 1'b0);
    rst = 1'b0; cap_ab = '0; cap_ba = '0; sel_ab = '1; sel_ba = '1;
    // R1: reset cleared registers despite capture strobes during reset
    step("R1", 1'b1);

    // R2 R3: capture then read stored data while live buses change
    a_in = 16'h1234; b_in = 16'hFEDC; cap_ab = '1; cap_ba = '1; oe_n = '0; dir = 2'b01;
    step("R2 R3", 1'b1);
    cap_ab = '0; cap_ba = '0; a_in = 16'h0F0F; b_in = 16'hF0F0;
    step("R2 R3", 1'b1);
    sel_ab = '0; sel_ba = '0;
    step("R4 R5", 1'b1);

    // R8: isolation, both registers load in one edge
    oe_n = '1; a_in = 16'h6699; b_in = 16'h9966; cap_ab = '1; cap_ba = '1;
    step("R8", 1'b1);
    cap_ab = '0; cap_ba = '0; a_in = 16'h0000; b_in = 16'hFFFF; sel_ab = '1; sel_ba = '1;
    step("R8", 1'b1);

    // R6 R9: lane 0 sweeps all enable/dir/select combos, lane 1 frozen
    oe_n[1] = 1'b0; dir[1] = 1'b1; sel_ab[1] = 1'b0; sel_ba[1] = 1'b1;
    for (int k = 0; k < 16; k++) begin
      {oe_n[0], dir[0], sel_ab[0], sel_ba[0]} = 4'(k);
      a_in = 16'(k * 16'h1111); b_in = ~16'(k * 16'h0101);
      step("R6 R9", 1'b1);
    end
    // same sweep on lane 1 with lane 0 capturing
    oe_n[0] = 1'b0; dir[0] = 1'b0; cap_ab[0] = 1'b1;
    for (int k = 0; k < 16; k++) begin
      {oe_n[1], dir[1], sel_ab[1], sel_ba[1]} = 4'(k);
      a_in = 16'(k * 16'h0707); b_in = 16'(k * 16'h1357);
      step("R6 R9 R10", 1'b1);
    end
    cap_ab = '0;

    // R4 R5 R2 R3: random traffic including selects equal to stored data
    for (int i = 0; i < 2000; i++) begin
      a_in = 16'($urandom); b_in = 16'($urandom);
      {oe_n, dir, sel_ab, sel_ba, cap_ab, cap_ba} = 12'($urandom);
      rst = ($urandom_range(0, 99) == 0);
      step("R2 R3 R4 R5 R6", 1'b1);
    end
    rst = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule